// File: doc/BRIEF.md
# Serial ADC Device-Side Interface

This block is a cycle-accurate digital stand-in for the serial port of an eight-input, 10-bit successive-approximation converter. A host controller under test can talk to it exactly as it would talk to the real converter. It runs on a fast system clock and oversamples the host's serial clock, select and data lines. A select fall arms it. The first high bit on the data line is the start bit. A mode bit and a channel address follow that start bit.

After a one-and-a-half-clock sample window, the block drives a low null bit. It then sends the 10-bit code most-significant bit first, then sends the same code again least-significant bit first, and after that sends zeros for as long as the host keeps clocking. Raising select stops the transfer at any point and floats the output.

The codes come from eight channel registers. The testbench loads them through a valid/ready write stream. That stream never applies back-pressure: `wr_ready` is high in every cycle, and each cycle with `wr_valid` high writes one register. In differential mode the code is the difference between the two inputs of a pair, clipped at zero. A status port shows the decoded mode and address.

Top module: `sadc_serial_dev`

## Requirements
- R1: After reset `dout_en` and `stat_vld` are 0. If `cs_n` is already low when reset ends, no transfer starts until `cs_n` has gone high and then low again.
- R2: After a `cs_n` fall, low `din` bits sampled on `sclk` rises are ignored. The first high one is the start bit.
- R3: The next four `din` bits sampled on rises are the mode bit (1 = single-ended, 0 = differential) and then the address, most-significant bit first. After the fourth of these bits, `stat_vld` is 1 and `stat_single`/`stat_ch` hold the decoded values.
- R4: `dout_en` stays 0 until the second `sclk` fall after the rise that took the last address bit. At that fall `dout_en` becomes 1 and `dout` is 0 (the null bit).
- R5: The next ten falls put code bits 9 down to 0 on `dout`.
- R6: The nine falls after that put code bits 1 up to 9 on `dout`. Every later fall with `cs_n` low puts out 0.
- R7: `dout` changes only after an `sclk` fall. An `sclk` rise never changes it.
- R8: `cs_n` high clears `dout_en` and `stat_vld` and ends the transfer. Start bits sent after a finished transfer, while `cs_n` stays low, have no effect.
- R9: In single-ended mode the code is the register of the addressed channel.
- R10: In differential mode the positive input is channel `a` and the negative input is channel `a^1`. The code is positive minus negative, or 0 when that difference would be negative.
- R11: The code is captured in the system-clock cycle that acts on the null-bit fall. A write sampled in that same cycle is not seen. A write sampled one cycle earlier is seen.
- R12: `wr_ready` is always 1. Each cycle with `wr_valid` high loads `wr_code` into channel `wr_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Host command data |
| dout | output | 1 | Serial result data |
| dout_en | output | 1 | Output enable; 0 means high impedance |
| wr_valid | input | 1 | Channel register write valid |
| wr_ready | output | 1 | Always 1 |
| wr_ch | input | 3 | Channel to write |
| wr_code | input | 10 | Code to store |
| stat_vld | output | 1 | Command decoded in this transfer |
| stat_single | output | 1 | Decoded mode, 1 = single-ended |
| stat_ch | output | 3 | Decoded address |

## Verification
A register write and the capture of the code can land in the same system-clock cycle, namely the cycle that acts on the null-bit fall. The bench places a write in exactly that cycle and, in a second transfer, one cycle earlier. It judges the outcome from the code read back. The same-cycle write must yield the old value, and the early write must yield the new one. A following transfer then checks that the same-cycle write did land in the register.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_STBY,
    ST_HUNT,
    ST_CMD,
    ST_SAMP,
    ST_OUT
  } sadc_state_e;
endpackage

// File: rtl/sadc_pin_sync.sv
module sadc_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_hi,
  output logic din_s
);
  logic sclk_q, sclk_qq, cs_q, cs_qq;

  // select resets to "low" so a select already low at reset exit is no fall
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      cs_q    <= 1'b0;
      cs_qq   <= 1'b0;
      din_s   <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      sclk_qq <= sclk_q;
      cs_q    <= cs_n;
      cs_qq   <= cs_q;
      din_s   <= din;
    end
  end

  assign sclk_rise = sclk_q & ~sclk_qq;
  assign sclk_fall = ~sclk_q & sclk_qq;
  assign cs_fall   = ~cs_q & cs_qq;
  assign cs_hi     = cs_q;
endmodule

// File: rtl/sadc_chan_bank.sv
module sadc_chan_bank #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_ch,
  input  logic [RES_W-1:0]  wr_code,
  input  logic              sel_single,
  input  logic [ADDR_W-1:0] sel_ch,
  output logic [RES_W-1:0]  code
);
  logic [RES_W-1:0] regs [NUM_CH];
  logic [RES_W-1:0] pos_v, neg_v;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_valid && wr_ch == ADDR_W'(g))
        regs[g] <= wr_code;
    end
  end

  // pair partner differs only in the lowest address bit
  assign pos_v = regs[sel_ch];
  assign neg_v = regs[sel_ch ^ ADDR_W'(1)];

  always_comb begin
    if (sel_single)
      code = pos_v;
    else if (pos_v > neg_v)
      code = pos_v - neg_v;
    else
      code = '0;
  end
endmodule

// File: rtl/sadc_bit_pick.sv
module sadc_bit_pick #(
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(2 * RES_W + 1)
) (
  input  logic [RES_W-1:0] res,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  // idx 1..W: MSB-first, idx W+1..2W-1: LSB-first echo from bit 1, else 0
  always_comb begin
    bit_o = 1'b0;
    for (int b = 0; b < RES_W; b++) begin
      if (idx == IDX_W'(RES_W - b))
        bit_o = res[b];
      else if (b >= 1 && idx == IDX_W'(RES_W + b))
        bit_o = res[b];
    end
  end
endmodule

// File: rtl/sadc_serial_dev.sv
module sadc_serial_dev #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int ADDR_W = $clog2(NUM_CH),
  localparam int CMD_W  = ADDR_W + 1,
  localparam int BCNT_W = $clog2(CMD_W),
  localparam int IDX_W  = $clog2(2 * RES_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_ch,
  input  logic [RES_W-1:0]  wr_code,
  output logic              stat_vld,
  output logic              stat_single,
  output logic [ADDR_W-1:0] stat_ch
);
  import sadc_pkg::*;

  sadc_state_e       state;
  logic              sclk_rise, sclk_fall, cs_fall, cs_hi, din_s;
  logic [CMD_W-1:0]  cmd;
  logic [BCNT_W-1:0] bcnt;
  logic              scnt;
  logic [IDX_W-1:0]  fcnt;
  logic [RES_W-1:0]  res_q, bank_code;
  logic              pick_bit;

  sadc_pin_sync i_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_hi(cs_hi), .din_s(din_s)
  );

  sadc_chan_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ch(wr_ch),
    .wr_code(wr_code), .sel_single(cmd[CMD_W-1]), .sel_ch(cmd[ADDR_W-1:0]),
    .code(bank_code)
  );

  sadc_bit_pick #(.RES_W(RES_W)) i_pick (
    .res(res_q), .idx(fcnt), .bit_o(pick_bit)
  );

  assign wr_ready    = 1'b1;
  assign stat_single = cmd[CMD_W-1];
  assign stat_ch     = cmd[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_STBY;
      cmd      <= '0;
      bcnt     <= '0;
      scnt     <= 1'b0;
      fcnt     <= '0;
      res_q    <= '0;
      dout     <= 1'b0;
      dout_en  <= 1'b0;
      stat_vld <= 1'b0;
    end else if (cs_hi) begin
      state    <= ST_STBY;
      dout_en  <= 1'b0;
      stat_vld <= 1'b0;
    end else begin
      case (state)
        ST_STBY: if (cs_fall) state <= ST_HUNT;
        ST_HUNT: if (sclk_rise && din_s) begin
          state <= ST_CMD;
          bcnt  <= '0;
        end
        ST_CMD: if (sclk_rise) begin
          cmd <= {cmd[CMD_W-2:0], din_s};
          if (bcnt == BCNT_W'(CMD_W - 1)) begin
            state    <= ST_SAMP;
            scnt     <= 1'b0;
            stat_vld <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_SAMP: if (sclk_fall) begin
          if (scnt) begin
            state   <= ST_OUT;
            res_q   <= bank_code;
            dout    <= 1'b0;
            dout_en <= 1'b1;
            fcnt    <= IDX_W'(1);
          end else begin
            scnt <= 1'b1;
          end
        end
        ST_OUT: if (sclk_fall) begin
          dout <= pick_bit;
          if (fcnt != IDX_W'(2 * RES_W)) fcnt <= fcnt + 1'b1;
        end
        default: state <= ST_STBY;
      endcase
    end
  end
endmodule

// File: rtl/sadc_serial_dev_chk.sv
module sadc_serial_dev_chk #(
  parameter int ADDR_W = 3,
  parameter int RES_W  = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  dout,
  input logic                  dout_en,
  input logic                  stat_vld,
  input logic                  stat_single,
  input logic [ADDR_W-1:0]     stat_ch,
  input logic                  sclk_fall,
  input sadc_pkg::sadc_state_e state,
  input logic [RES_W-1:0]      res_q
);
  import sadc_pkg::*;

  a_r8_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !dout_en);

  a_r8_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !stat_vld);

  a_r4_null_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> !dout);

  a_r7_dout_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && $past(dout_en) && !$stable(dout)) |-> $past(sclk_fall));

  a_r3_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && $past(stat_vld)) |-> ($stable(stat_ch) && $stable(stat_single)));

  a_r11_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && $past(state == ST_OUT)) |-> $stable(res_q));
endmodule

bind sadc_serial_dev sadc_serial_dev_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout), .dout_en(dout_en),
  .stat_vld(stat_vld), .stat_single(stat_single), .stat_ch(stat_ch),
  .sclk_fall(sclk_fall), .state(state), .res_q(res_q)
);

// File: tb/test_sadc_serial_dev.sv
`timescale 1ns/1ps
module test_sadc_serial_dev;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b0, din = 1'b0;
  logic dout, dout_en, wr_valid = 1'b0, wr_ready;
  logic [2:0] wr_ch = '0;
  logic [9:0] wr_code = '0;
  logic stat_vld, stat_single;
  logic [2:0] stat_ch;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [9:0] mem [8];

  always #2 clk = ~clk;

  sadc_serial_dev i_sadc_serial_dev (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_en(dout_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ch(wr_ch), .wr_code(wr_code), .stat_vld(stat_vld),
    .stat_single(stat_single), .stat_ch(stat_ch)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] code_of(input bit single, input int ch);
    logic [9:0] p, n;
    p = mem[ch];
    n = mem[ch ^ 1];
    if (single) return p;
    return (p > n) ? p - n : 10'd0;
  endfunction

  task automatic wr(input int ch, input logic [9:0] code);
    @(negedge clk);
    chk(wr_ready == 1'b1, "R12 ready", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_ch = 3'(ch); wr_code = code;
    @(negedge clk);
    wr_valid = 1'b0;
    mem[ch] = code;
  endtask

  task automatic half(input bit s);
    @(negedge clk) sclk = s;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    din = b;
    half(1'b1);
    half(1'b0);
  endtask

  // wmode: 0 none, 1 write one cycle before capture, 2 write in capture cycle
  task automatic xfer(input bit single, input int ch, input int pre, input int nread,
                      input int wmode, input int wch, input logic [9:0] wcode);
    logic [9:0] exp, act_msb, act_echo;
    int zeros_bad, r7_bad;
    logic prev;
    act_msb = '0; act_echo = '0; zeros_bad = 0; r7_bad = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < pre; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(single);
    for (int i = 2; i >= 0; i--) send_bit(ch[i]);
    chk(stat_vld && stat_single == single && stat_ch == 3'(ch), "R3 decode",
        {stat_vld, stat_single, stat_ch}, {1'b1, single, 3'(ch)});
    chk(!dout_en, "R4 float before null", int'(dout_en), 0);
    exp = code_of(single, ch);
    half(1'b1);
    if (wmode == 1) begin
      @(negedge clk) sclk = 1'b0; wr_valid = 1'b1; wr_ch = 3'(wch); wr_code = wcode;
      @(negedge clk) wr_valid = 1'b0;
      repeat (2) @(negedge clk);
      mem[wch] = wcode;
      exp = code_of(single, ch);
    end else if (wmode == 2) begin
      @(negedge clk) sclk = 1'b0;
      @(negedge clk) wr_valid = 1'b1; wr_ch = 3'(wch); wr_code = wcode;
      @(negedge clk) wr_valid = 1'b0;
      @(negedge clk);
      mem[wch] = wcode;
    end else begin
      half(1'b0);
    end
    chk(dout_en && !dout, "R4 null bit", {dout_en, dout}, 2'b10);
    prev = dout;
    for (int j = 1; j <= nread; j++) begin
      half(1'b1);
      if (dout !== prev) r7_bad++;
      half(1'b0);
      prev = dout;
      if (j <= 10) act_msb[10 - j] = dout;
      else if (j <= 19) act_echo[j - 10] = dout;
      else if (dout !== 1'b0) zeros_bad++;
    end
    chk(r7_bad == 0, "R7 no change on rise", r7_bad, 0);
    if (nread >= 10)
      chk(act_msb == exp, single ? "R5/R9 msb-first code" : "R5/R10 msb-first code",
          int'(act_msb), int'(exp));
    if (nread >= 31) begin
      chk(act_echo[9:1] == exp[9:1], "R6 lsb-first echo", int'(act_echo), int'({exp[9:1], 1'b0}));
      chk(zeros_bad == 0, "R6 trailing zeros", zeros_bad, 0);
    end
  endtask

  task automatic end_xfer();
    @(negedge clk) cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!dout_en && !stat_vld, "R8 deselect", {dout_en, stat_vld}, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dout_en && !stat_vld, "R1 reset state", {dout_en, stat_vld}, 0);
    // R1: select low since reset, commands must be ignored
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    for (int j = 0; j < 4; j++) send_bit(1'b0);
    chk(!dout_en && !stat_vld, "R1 no start without select fall", {dout_en, stat_vld}, 0);
    end_xfer();

    for (int i = 0; i < 8; i++)
      wr(i, (i == 0) ? 10'h000 : (i == 7) ? 10'h3FF : 10'((i * 'h93 + 'h51) & 'h3FF));

    // R2 R9 sweep single-ended with leading zeros before the start bit
    for (int c = 0; c < 8; c++) begin
      xfer(1'b1, c, c % 3, 31, 0, 0, '0);
      end_xfer();
    end
    // R10 sweep differential
    for (int c = 0; c < 8; c++) begin
      xfer(1'b0, c, (c + 1) % 3, 31, 0, 0, '0);
      end_xfer();
    end

    // R8 abort mid-result, then a clean transfer
    xfer(1'b1, 2, 0, 4, 0, 0, '0);
    end_xfer();
    xfer(1'b1, 3, 1, 31, 0, 0, '0);
    // R8 a second command while still selected is ignored
    begin
      int bad;
      bad = 0;
      din = 1'b1; half(1'b1); half(1'b0);
      din = 1'b0; half(1'b1); half(1'b0);
      din = 1'b1; half(1'b1); half(1'b0);
      for (int j = 0; j < 6; j++) begin
        din = 1'b0; half(1'b1); half(1'b0);
        if (dout !== 1'b0 || !dout_en) bad++;
      end
      chk(bad == 0 && stat_ch == 3'd3 && stat_single, "R8 restart ignored", bad, 0);
    end
    end_xfer();

    // R11 write one cycle before capture is seen, write in capture cycle is not
    xfer(1'b1, 5, 0, 31, 1, 5, 10'h2AA);
    end_xfer();
    xfer(1'b1, 5, 0, 31, 2, 5, 10'h155);
    end_xfer();
    xfer(1'b1, 5, 2, 31, 0, 0, '0);
    end_xfer();
    // R11 differential capture with a same-cycle write to the partner
    xfer(1'b0, 4, 0, 31, 2, 5, 10'h000);
    end_xfer();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule